// File: doc/BRIEF.md
# Trace Timestamp Source Selector

This block turns a free-running 64-bit physical count into the timestamp that a trace unit puts into its output. A hypervisor-owned 2-bit timebase field chooses the time base. The choices are the raw count, the count minus a virtual offset, or the count minus a guest physical offset. The field can also pass the choice down to a 2-bit field set at a lower privilege level. A self-hosted-trace enable gates the whole choice: while it is low, the raw count is used.

The offset is subtracted first. The result is then held in an output register and updated only on cycles where the incoming count is marked valid. A valid flag comes out one clock after each input beat. A build parameter can remove the guest physical offset path, which makes that timebase equal to the raw count.

Top module: `trace_tstamp_sel`

## Requirements
- R1: While `rst_n` is low, `tstamp_o` is 0 and `tstamp_valid_o` is 0.
- R2: The hypervisor timebase field is bits [6:5] of `ctrl_word_i`. No other bit of `ctrl_word_i` changes the output.
- R3: Field value 01 selects `counter_i - virt_offset_i`.
- R4: Field value 10 selects `counter_i - phys_offset_i` when `phys_offset_en_i` is 1. When `phys_offset_en_i` is 0, the offset is treated as zero and the output is `counter_i`.
- R5: Field value 11 selects `counter_i` unchanged.
- R6: Field value 00 hands the choice to `low_sel_i`. There, 01 selects the virtual offset, 10 selects the guest physical offset (qualified as in R4), and both 00 and 11 select the raw counter.
- R7: While `self_hosted_en_i` is 0, both fields are ignored and the output is `counter_i`.
- R8: Every subtraction is taken modulo 2^64 and wraps without any indication.
- R9: When `counter_valid_i` is 1 at a rising edge, `tstamp_o` takes the selected value at that edge. `tstamp_valid_o` always equals `counter_valid_i` from the previous edge.
- R10: When `counter_valid_i` is 0 at a rising edge, `tstamp_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| counter_i | input | 64 | Physical counter value |
| counter_valid_i | input | 1 | Counter value is valid this cycle |
| virt_offset_i | input | 64 | Virtual offset |
| phys_offset_i | input | 64 | Guest physical offset |
| phys_offset_en_i | input | 1 | Guest physical offset qualifier |
| ctrl_word_i | input | 8 | Hypervisor control word, timebase field at [6:5] |
| low_sel_i | input | 2 | Lower-privilege timebase field |
| self_hosted_en_i | input | 1 | Self-hosted trace enabled |
| tstamp_o | output | 64 | Registered timestamp |
| tstamp_valid_o | output | 1 | Timestamp valid |

## Verification
Both outputs are due at the first rising edge after the inputs are presented, because exactly one register lies between any input and any output. The bench drives each beat at the falling edge and computes the expected result at the same moment. It then compares one nanosecond after the next rising edge. For beats with `counter_valid_i` low, the expected timestamp is the one the bench model already holds, so the hold behaviour is checked in that same cycle.

// File: rtl/tts_pkg.sv
package tts_pkg;

  // Resolved time base used by the datapath
  typedef enum logic [1:0] {
    EM_RAW   = 2'd0,
    EM_VIRT  = 2'd1,
    EM_GUEST = 2'd2
  } eff_mode_e;

  // Encodings of the hypervisor field; the lower-privilege field shares them
  localparam logic [1:0] TB_DEFER = 2'b00;
  localparam logic [1:0] TB_VIRT  = 2'b01;
  localparam logic [1:0] TB_GUEST = 2'b10;
  localparam logic [1:0] TB_RAW   = 2'b11;

  // Lower-privilege code: 00 and 11 both give the raw counter
  function automatic eff_mode_e decode_low(input logic [1:0] code);
    eff_mode_e m;
    unique case (code)
      TB_VIRT:  m = EM_VIRT;
      TB_GUEST: m = EM_GUEST;
      default:  m = EM_RAW;
    endcase
    return m;
  endfunction

  function automatic eff_mode_e resolve_mode(input logic [1:0] hyp,
                                             input logic [1:0] low,
                                             input logic       sh_en);
    eff_mode_e m;
    if (!sh_en) begin
      m = EM_RAW;
    end else begin
      unique case (hyp)
        TB_DEFER: m = decode_low(low);
        TB_VIRT:  m = EM_VIRT;
        TB_GUEST: m = EM_GUEST;
        default:  m = EM_RAW;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/tts_mode_resolve.sv
module tts_mode_resolve
  import tts_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int TS_LSB = 5
) (
  input  logic [1:0]  hyp_field_i,
  input  logic [1:0]  low_sel_i,
  input  logic        sh_en_i,
  output eff_mode_e   mode_o,
  output logic        delegated_o
);

  always_comb begin
    mode_o      = resolve_mode(hyp_field_i, low_sel_i, sh_en_i);
    delegated_o = sh_en_i && (hyp_field_i == TB_DEFER);
  end

endmodule

// File: rtl/tts_offset_mux.sv
module tts_offset_mux
  import tts_pkg::*;
#(
  parameter int TS_W         = 64,
  parameter bit GUEST_OFS_EN = 1'b1
) (
  input  eff_mode_e         mode_i,
  input  logic [TS_W-1:0]   virt_offset_i,
  input  logic [TS_W-1:0]   phys_offset_i,
  input  logic              phys_offset_en_i,
  output logic [TS_W-1:0]   offset_o,
  output logic              guest_zeroed_o
);

  logic [TS_W-1:0] guest_ofs;
  logic            guest_ok;

  generate
    if (GUEST_OFS_EN) begin : g_guest
      assign guest_ok  = phys_offset_en_i;
      assign guest_ofs = phys_offset_en_i ? phys_offset_i : '0;
    end else begin : g_no_guest
      assign guest_ok  = 1'b0;
      assign guest_ofs = '0;
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      EM_VIRT:  offset_o = virt_offset_i;
      EM_GUEST: offset_o = guest_ofs;
      default:  offset_o = '0;
    endcase
    guest_zeroed_o = (mode_i == EM_GUEST) && !guest_ok;
  end

endmodule

// File: rtl/tts_stamp_reg.sv
module tts_stamp_reg #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] counter_i,
  input  logic [TS_W-1:0] offset_i,
  input  logic            counter_valid_i,
  output logic [TS_W-1:0] tstamp_o,
  output logic            tstamp_valid_o,
  output logic            capture_o
);

  // Modulo 2^TS_W difference; carry out is discarded on purpose
  function automatic logic [TS_W-1:0] wrap_sub(input logic [TS_W-1:0] a,
                                               input logic [TS_W-1:0] b);
    return a - b;
  endfunction

  logic [TS_W-1:0] diff;

  assign diff      = wrap_sub(counter_i, offset_i);
  assign capture_o = counter_valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tstamp_o       <= '0;
      tstamp_valid_o <= 1'b0;
    end else begin
      tstamp_valid_o <= counter_valid_i;
      if (capture_o) begin
        tstamp_o <= diff;
      end
    end
  end

endmodule

// File: rtl/trace_tstamp_sel.sv
module trace_tstamp_sel
  import tts_pkg::*;
#(
  parameter int TS_W         = 64,
  parameter int CTRL_W       = 8,
  parameter int TS_LSB       = 5,
  parameter bit GUEST_OFS_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   counter_i,
  input  logic              counter_valid_i,
  input  logic [TS_W-1:0]   virt_offset_i,
  input  logic [TS_W-1:0]   phys_offset_i,
  input  logic              phys_offset_en_i,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  input  logic [1:0]        low_sel_i,
  input  logic              self_hosted_en_i,
  output logic [TS_W-1:0]   tstamp_o,
  output logic              tstamp_valid_o
);

  localparam int TS_MSB = TS_LSB + 1;

  // Named internal events for the checker
  logic [1:0]      hyp_field;
  eff_mode_e       eff_mode;
  logic            delegated;
  logic [TS_W-1:0] sel_offset;
  logic            guest_zeroed;
  logic            capture;

  assign hyp_field = ctrl_word_i[TS_MSB:TS_LSB];

  tts_mode_resolve #(
    .CTRL_W (CTRL_W),
    .TS_LSB (TS_LSB)
  ) i_resolve (
    .hyp_field_i (hyp_field),
    .low_sel_i   (low_sel_i),
    .sh_en_i     (self_hosted_en_i),
    .mode_o      (eff_mode),
    .delegated_o (delegated)
  );

  tts_offset_mux #(
    .TS_W         (TS_W),
    .GUEST_OFS_EN (GUEST_OFS_EN)
  ) i_ofs (
    .mode_i           (eff_mode),
    .virt_offset_i    (virt_offset_i),
    .phys_offset_i    (phys_offset_i),
    .phys_offset_en_i (phys_offset_en_i),
    .offset_o         (sel_offset),
    .guest_zeroed_o   (guest_zeroed)
  );

  tts_stamp_reg #(
    .TS_W (TS_W)
  ) i_reg (
    .clk             (clk),
    .rst_n           (rst_n),
    .counter_i       (counter_i),
    .offset_i        (sel_offset),
    .counter_valid_i (counter_valid_i),
    .tstamp_o        (tstamp_o),
    .tstamp_valid_o  (tstamp_valid_o),
    .capture_o       (capture)
  );

endmodule

// File: rtl/tts_chk.sv
module tts_chk
  import tts_pkg::*;
#(
  parameter int TS_W   = 64,
  parameter int CTRL_W = 8,
  parameter int TS_LSB = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TS_W-1:0]   counter_i,
  input logic              counter_valid_i,
  input logic [TS_W-1:0]   virt_offset_i,
  input logic [CTRL_W-1:0] ctrl_word_i,
  input logic [1:0]        low_sel_i,
  input logic              self_hosted_en_i,
  input logic              phys_offset_en_i,
  input eff_mode_e         eff_mode,
  input logic [TS_W-1:0]   sel_offset,
  input logic              delegated,
  input logic [TS_W-1:0]   tstamp_o,
  input logic              tstamp_valid_o
);

  logic [1:0] fld;
  assign fld = ctrl_word_i[TS_LSB+1:TS_LSB];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (tstamp_o == '0) && !tstamp_valid_o);

  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    counter_valid_i |=> tstamp_valid_o);

  // R9
  valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !counter_valid_i |=> !tstamp_valid_o);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!counter_valid_i && $past(rst_n)) |=> $stable(tstamp_o));

  // R7
  sh_off_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counter_valid_i && !self_hosted_en_i) |=> tstamp_o == $past(counter_i));

  // R5
  raw_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counter_valid_i && self_hosted_en_i && fld == TB_RAW)
      |=> tstamp_o == $past(counter_i));

  // R3
  virt_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counter_valid_i && self_hosted_en_i && fld == TB_VIRT)
      |=> tstamp_o == $past(counter_i) - $past(virt_offset_i));

  // R6
  defer_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counter_valid_i && delegated && low_sel_i == TB_VIRT)
      |=> tstamp_o == $past(counter_i) - $past(virt_offset_i));

  // R4
  guest_unq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == EM_GUEST && !phys_offset_en_i) |-> sel_offset == '0);

  // R6
  raw_zero_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == EM_RAW) |-> sel_offset == '0);

endmodule

bind trace_tstamp_sel tts_chk #(
  .TS_W   (TS_W),
  .CTRL_W (CTRL_W),
  .TS_LSB (TS_LSB)
) i_tts_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .counter_i        (counter_i),
  .counter_valid_i  (counter_valid_i),
  .virt_offset_i    (virt_offset_i),
  .ctrl_word_i      (ctrl_word_i),
  .low_sel_i        (low_sel_i),
  .self_hosted_en_i (self_hosted_en_i),
  .phys_offset_en_i (phys_offset_en_i),
  .eff_mode         (eff_mode),
  .sel_offset       (sel_offset),
  .delegated        (delegated),
  .tstamp_o         (tstamp_o),
  .tstamp_valid_o   (tstamp_valid_o)
);

// File: tb/test_trace_tstamp_sel.sv
`timescale 1ns/1ps
module test_trace_tstamp_sel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] counter_i, virt_offset_i, phys_offset_i;
  logic        counter_valid_i, phys_offset_en_i, self_hosted_en_i;
  logic [7:0]  ctrl_word_i;
  logic [1:0]  low_sel_i;
  logic [63:0] tstamp_o;
  logic        tstamp_valid_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [63:0] exp_ts;

  always #2 clk = ~clk;  // 250 MHz

  trace_tstamp_sel i_trace_tstamp_sel (
    .clk              (clk),
    .rst_n            (rst_n),
    .counter_i        (counter_i),
    .counter_valid_i  (counter_valid_i),
    .virt_offset_i    (virt_offset_i),
    .phys_offset_i    (phys_offset_i),
    .phys_offset_en_i (phys_offset_en_i),
    .ctrl_word_i      (ctrl_word_i),
    .low_sel_i        (low_sel_i),
    .self_hosted_en_i (self_hosted_en_i),
    .tstamp_o         (tstamp_o),
    .tstamp_valid_o   (tstamp_valid_o)
  );

  // Bench view of the time base: 0 raw, 1 virtual, 2 guest
  function automatic int base_of(logic [7:0] cw, logic [1:0] lo, logic sh);
    int b;
    if (!sh) return 0;
    b = int'(cw[6:5]);
    if (b == 0) b = int'(lo);
    if (b == 3) b = 0;
    return b;
  endfunction

  function automatic logic [63:0] model(logic [63:0] cnt, logic [63:0] v,
                                        logic [63:0] p, logic pen,
                                        logic [7:0] cw, logic [1:0] lo,
                                        logic sh);
    case (base_of(cw, lo, sh))
      1:       return cnt + (~v + 64'd1);
      2:       return pen ? cnt + (~p + 64'd1) : cnt;
      default: return cnt;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] cw, logic sh);
    if (!sh) return "R7";
    case (cw[6:5])
      2'b00:   return "R6";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One beat: drive at falling edge, compare 1 ns after the next rising edge
  task automatic beat(logic cv, logic [7:0] cw, logic [1:0] lo, logic sh,
                      logic pen, logic [63:0] cnt, logic [63:0] v,
                      logic [63:0] p, string tag);
    @(negedge clk);
    counter_valid_i  = cv;
    ctrl_word_i      = cw;
    low_sel_i        = lo;
    self_hosted_en_i = sh;
    phys_offset_en_i = pen;
    counter_i        = cnt;
    virt_offset_i    = v;
    phys_offset_i    = p;
    if (cv) exp_ts = model(cnt, v, p, pen, cw, lo, sh);
    @(posedge clk);
    #1;
    check64(tag, tstamp_o, exp_ts);
    check64("R9", {63'd0, tstamp_valid_o}, {63'd0, cv});
  endtask

  initial begin
    rst_n = 1'b0;
    counter_valid_i = 1'b1; ctrl_word_i = 8'hFF; low_sel_i = 2'b01;
    self_hosted_en_i = 1'b1; phys_offset_en_i = 1'b1;
    counter_i = 64'h1234; virt_offset_i = 64'h10; phys_offset_i = 64'h20;
    exp_ts = 64'd0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check64("R1", tstamp_o, 64'd0);
    check64("R1", {63'd0, tstamp_valid_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 virtual offset
    beat(1, 8'b0010_0000, 2'b00, 1, 1, 64'd1000, 64'd300, 64'd7, "R3");
    // R8 wrap on virtual subtraction: 5 - 10
    beat(1, 8'b0010_0000, 2'b00, 1, 1, 64'd5, 64'd10, 64'd0, "R8");
    // R4 guest offset qualified and unqualified
    beat(1, 8'b0100_0000, 2'b00, 1, 1, 64'd900, 64'd1, 64'd400, "R4");
    beat(1, 8'b0100_0000, 2'b00, 1, 0, 64'd900, 64'd1, 64'd400, "R4");
    // R8 wrap on guest subtraction: 0 - 1
    beat(1, 8'b0100_0000, 2'b00, 1, 1, 64'd0, 64'd0, 64'd1, "R8");
    // R5 raw
    beat(1, 8'b0110_0000, 2'b01, 1, 1, 64'hDEAD_BEEF_0000_0001, 64'd5, 64'd6, "R5");
    // R6 delegation, each lower-privilege code
    for (int lo = 0; lo < 4; lo++)
      beat(1, 8'b0000_0000, 2'(lo), 1, 1, 64'd5000, 64'd123, 64'd456, "R6");
    // R7 self-hosted disabled overrides a virtual selection
    beat(1, 8'b0010_0000, 2'b01, 0, 1, 64'd777, 64'd100, 64'd200, "R7");
    // R2 bits outside [6:5] have no effect: all other bits set, field 01
    beat(1, 8'b1011_1111, 2'b10, 1, 1, 64'd2000, 64'd50, 64'd60, "R2");
    // R10 hold with changing inputs while not valid
    beat(0, 8'b0110_0000, 2'b00, 1, 1, 64'd99999, 64'd3, 64'd4, "R10");
    beat(0, 8'b0000_0000, 2'b01, 0, 0, 64'd12345, 64'd3, 64'd4, "R10");

    // Constrained random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      logic        cv, sh, pen;
      logic [7:0]  cw;
      logic [1:0]  lo;
      logic [63:0] cnt, v, p;
      cv  = ($urandom % 8) != 0;
      sh  = ($urandom % 6) != 0;
      pen = $urandom;
      cw  = $urandom;
      lo  = $urandom;
      cnt = {$urandom, $urandom};
      v   = ($urandom % 4 == 0) ? ~64'd0 : {$urandom, $urandom};
      p   = {$urandom, $urandom};
      beat(cv, cw, lo, sh, pen, cnt, v, p, cv ? tag_of(cw, sh) : "R10");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule